// File: doc/BRIEF.md
# Master-Mode Audio Clock Divider

This block produces the serial audio frame clock and bit clock from a single fast master clock when the converter acts as clock master. A two-bit speed code selects one of three frame rates relative to the master clock, or hands clocking to an external source. A static "fast master clock" flag doubles every divide ratio. This covers the case where the master clock runs at twice the minimum ratio for the chosen speed.

Everything is derived from one free-running count in the master clock domain. The frame clock is provided as a level. The bit clock is provided as two single-cycle enables that mark its falling and rising edges. Logic running on the master clock can use these enables directly. A pad stage can use them to rebuild the bit clock pin. A separate output reports whether the block is driving the clock pins, so the pad direction can follow it.

The speed code and fast flag are sampled only while reset is held. The counter stays cleared during reset and starts at count zero in the first cycle after reset is released.

Top module: `clkdiv_master`

## Requirements
- R1: Speed code 2'b00, 2'b01 and 2'b10 select master operation and set `clk_drive_o` high. Code 2'b11 selects external clocking and sets `clk_drive_o` low.
- R2: In master operation the frame period is 256, 128 or 64 master-clock cycles for codes 00, 01 and 10. Each period doubles when `fast_i` was high at reset.
- R3: The frame clock is low for the first half of each frame period and high for the second half. The first frame starts in the first cycle after reset release.
- R4: `sclk_fall_o` pulses once every period/64 cycles, starting at count 0, which gives 64 pulses per frame. Every frame clock transition falls in a cycle where `sclk_fall_o` is high.
- R5: `sclk_rise_o` pulses half a bit period after each `sclk_fall_o`. When the bit period is one master-clock cycle, both enables are high in every cycle.
- R6: Changes on `mode_i` or `fast_i` after reset release have no effect on any output until the next reset.
- R7: While `rst_ni` is low, `lrck_o`, `sclk_fall_o` and `sclk_rise_o` are 0, and the count is cleared.
- R8: With code 2'b11, `lrck_o`, `sclk_fall_o` and `sclk_rise_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Synchronous active-low reset; pins are sampled while low |
| mode_i | input | 2 | Speed code: 00 single, 01 double, 10 quad, 11 external clocking |
| fast_i | input | 1 | Master clock is twice the minimum ratio (enables the ÷2 prescale) |
| lrck_o | output | 1 | Frame clock level |
| sclk_fall_o | output | 1 | Enable marking a bit-clock falling edge |
| sclk_rise_o | output | 1 | Enable marking a bit-clock rising edge |
| clk_drive_o | output | 1 | High when the block drives the clock pins |

## Verification
The hardest condition to show from the ports is that a pin change made while the counter is running is ignored. Nothing inside is visible, so the only evidence is that the frame and bit pattern keep the ratio captured at reset. The stimulus flips the speed code and the fast flag partway through a frame. It then compares three frames of the ratio captured at reset against the ratio the new pins would give. The quad speed setting without the fast flag is also exercised, because there the bit period falls to a single cycle and both enables must stay high together.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_EXT    = 2'b11
    } speed_e;

    typedef struct packed {
        speed_e speed;
        logic   fast;
    } div_cfg_t;

    function automatic logic is_master(div_cfg_t c);
        return c.speed != SPD_EXT;
    endfunction

endpackage

// File: rtl/clkdiv_cfg_latch.sv
module clkdiv_cfg_latch
    import clkdiv_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mode_i,
    input  logic       fast_i,
    output div_cfg_t   cfg_o,
    output logic       run_o
);

    typedef struct packed {
        div_cfg_t cfg;
        logic     run;
    } latch_t;

    latch_t s_d, s_q;

    // Pins are followed while reset is low and frozen once it is released.
    always_comb begin
        s_d     = s_q;
        s_d.run = rst_ni;
        if (!rst_ni) begin
            s_d.cfg.speed = speed_e'(mode_i);
            s_d.cfg.fast  = fast_i;
        end
    end

    always_ff @(posedge clk_i) begin
        s_q <= s_d;
    end

    assign cfg_o = s_q.cfg;
    assign run_o = s_q.run;

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
    import clkdiv_pkg::*;
#(
    parameter int LOG_BASE = 8,
    parameter int CNT_W    = LOG_BASE + 1,
    parameter int LPW      = $clog2(CNT_W + 1)
) (
    input  logic             clk_i,
    input  div_cfg_t         cfg_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [LPW-1:0]   lp_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       s_d, s_q;
    logic [LPW-1:0]   lp;
    logic [CNT_W-1:0] wrap_mask;

    // log2 of the frame period: base, reduced per speed step, raised by prescale
    always_comb begin
        lp        = LPW'(LOG_BASE) - LPW'(cfg_i.speed) + LPW'(cfg_i.fast);
        wrap_mask = (CNT_W'(1) << lp) - CNT_W'(1);
        s_d       = s_q;
        if (run_i && is_master(cfg_i)) begin
            s_d.cnt = (s_q.cnt + CNT_W'(1)) & wrap_mask;
        end else begin
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign lp_o  = lp;

endmodule

// File: rtl/clkdiv_edge_decode.sv
module clkdiv_edge_decode
    import clkdiv_pkg::*;
#(
    parameter int LOG_BITS = 6,
    parameter int CNT_W    = 9,
    parameter int LPW      = 4
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [LPW-1:0]   lp_i,
    input  div_cfg_t         cfg_i,
    input  logic             run_i,
    output logic             lrck_o,
    output logic             fall_o,
    output logic             rise_o
);

    logic             active;
    logic [LPW-1:0]   ld;
    logic [CNT_W-1:0] phase_mask;
    logic [CNT_W-1:0] phase;
    logic [CNT_W-1:0] half_bit;
    logic [CNT_W-1:0] frame_sh;

    always_comb begin
        active     = run_i && is_master(cfg_i);
        ld         = lp_i - LPW'(LOG_BITS);
        phase_mask = (CNT_W'(1) << ld) - CNT_W'(1);
        phase      = cnt_i & phase_mask;
        half_bit   = (ld == '0) ? '0 : (CNT_W'(1) << (ld - LPW'(1)));
        frame_sh   = cnt_i >> (lp_i - LPW'(1));
        lrck_o     = active && frame_sh[0];
        fall_o     = active && (phase == '0);
        rise_o     = active && (phase == half_bit);
    end

endmodule

// File: rtl/clkdiv_master.sv
module clkdiv_master
    import clkdiv_pkg::*;
#(
    parameter int BASE_SINGLE    = 256,
    parameter int BITS_PER_FRAME = 64
) (
    input  logic       mclk_i,
    input  logic       rst_ni,
    input  logic [1:0] mode_i,
    input  logic       fast_i,
    output logic       lrck_o,
    output logic       sclk_fall_o,
    output logic       sclk_rise_o,
    output logic       clk_drive_o
);

    localparam int LOG_BASE = $clog2(BASE_SINGLE);
    localparam int LOG_BITS = $clog2(BITS_PER_FRAME);
    localparam int CNT_W    = LOG_BASE + 1;
    localparam int LPW      = $clog2(CNT_W + 1);

    div_cfg_t         cfg;
    logic             run;
    logic [CNT_W-1:0] cnt;
    logic [LPW-1:0]   lp;

    clkdiv_cfg_latch i_cfg (
        .clk_i  (mclk_i),
        .rst_ni (rst_ni),
        .mode_i (mode_i),
        .fast_i (fast_i),
        .cfg_o  (cfg),
        .run_o  (run)
    );

    clkdiv_counter #(
        .LOG_BASE (LOG_BASE),
        .CNT_W    (CNT_W),
        .LPW      (LPW)
    ) i_cnt (
        .clk_i (mclk_i),
        .cfg_i (cfg),
        .run_i (run),
        .cnt_o (cnt),
        .lp_o  (lp)
    );

    clkdiv_edge_decode #(
        .LOG_BITS (LOG_BITS),
        .CNT_W    (CNT_W),
        .LPW      (LPW)
    ) i_dec (
        .cnt_i  (cnt),
        .lp_i   (lp),
        .cfg_i  (cfg),
        .run_i  (run),
        .lrck_o (lrck_o),
        .fall_o (sclk_fall_o),
        .rise_o (sclk_rise_o)
    );

    assign clk_drive_o = is_master(cfg);

endmodule

// File: rtl/clkdiv_master_chk.sv
module clkdiv_master_chk #(
    parameter int HALF_MAX = 256
) (
    input logic mclk_i,
    input logic rst_ni,
    input logic lrck_o,
    input logic sclk_fall_o,
    input logic sclk_rise_o,
    input logic clk_drive_o
);

    localparam int LW = $clog2(HALF_MAX + 3) + 1;

    logic [LW-1:0] len_q;
    logic          prev_q;

    // Cycles the frame clock has held its level; saturates
    always_ff @(posedge mclk_i) begin
        if (!rst_ni) begin
            len_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            prev_q <= lrck_o;
            if (lrck_o != prev_q) begin
                len_q <= LW'(1);
            end else if (len_q != '1) begin
                len_q <= len_q + LW'(1);
            end
        end
    end

    // R2: a half frame never exceeds the largest half period (one cycle slack for the release edge)
    a_r2_half_bound: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        clk_drive_o |-> (len_q <= LW'(HALF_MAX + 1)));

    // R4: every frame clock transition coincides with a bit-clock falling edge
    a_r4_lrck_on_fall: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        ($rose(lrck_o) || $fell(lrck_o)) |-> sclk_fall_o);

    // R6: the drive direction is frozen while running
    a_r6_mode_held: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> $stable(clk_drive_o));

    // R8: external clocking keeps all generated clocks quiet
    a_r8_slave_quiet: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        !clk_drive_o |-> (!lrck_o && !sclk_fall_o && !sclk_rise_o));

endmodule

bind clkdiv_master clkdiv_master_chk #(.HALF_MAX(BASE_SINGLE)) i_chk (
    .mclk_i      (mclk_i),
    .rst_ni      (rst_ni),
    .lrck_o      (lrck_o),
    .sclk_fall_o (sclk_fall_o),
    .sclk_rise_o (sclk_rise_o),
    .clk_drive_o (clk_drive_o)
);

// File: tb/test_clkdiv_master.sv
module test_clkdiv_master;

    logic       mclk  = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode  = 2'b00;
    logic       fast  = 1'b0;
    logic       lrck, sfall, srise, drive;

    int vectors     = 0;
    int miscompares = 0;
    bit done        = 0;

    always #5 mclk = ~mclk;

    clkdiv_master i_clkdiv_master (
        .mclk_i      (mclk),
        .rst_ni      (rst_n),
        .mode_i      (mode),
        .fast_i      (fast),
        .lrck_o      (lrck),
        .sclk_fall_o (sfall),
        .sclk_rise_o (srise),
        .clk_drive_o (drive)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Hold reset with the given pins; check idle outputs (R7); release on a falling edge
    task automatic do_reset(input logic [1:0] m, input logic f);
        @(negedge mclk);
        rst_n = 1'b0;
        mode  = m;
        fast  = f;
        repeat (3) @(negedge mclk);
        chk(lrck == 0 && sfall == 0 && srise == 0, "R7 outputs idle in reset",
            int'({lrck, sfall, srise}), 0);
        rst_n = 1'b1;
    endtask

    // Compare against the expected pattern for period p; cycle 0 is the first after release
    task automatic scan(input int p, input int cycles, input int swap_at,
                        output int e_lr, output int e_fa, output int e_ri,
                        output int falls0, output int lr_rises);
        int  d;
        bit  prev;
        bit  x_lr, x_fa, x_ri;
        d = p / 64;
        prev = 0;
        e_lr = 0; e_fa = 0; e_ri = 0; falls0 = 0; lr_rises = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge mclk);
            x_lr = (k % p) >= (p / 2);
            x_fa = (k % d) == 0;
            x_ri = (d == 1) ? 1'b1 : ((k % d) == (d / 2));
            if (lrck !== x_lr) e_lr++;
            if (sfall !== x_fa) e_fa++;
            if (srise !== x_ri) e_ri++;
            if (k < p && sfall) falls0++;
            if (k > 0 && lrck && !prev) lr_rises++;
            prev = lrck;
            if (k == swap_at) begin
                mode = 2'b10;
                fast = ~fast;
            end
        end
    endtask

    task automatic run_master(input logic [1:0] m, input logic f);
        int p, e_lr, e_fa, e_ri, falls0, rises;
        p = (256 >> m) << f;
        do_reset(m, f);
        scan(p, 2 * p, -1, e_lr, e_fa, e_ri, falls0, rises);
        chk(drive == 1, $sformatf("R1 drive high mode=%0d", m), drive, 1);
        chk(e_lr == 0, $sformatf("R3 frame level mode=%0d fast=%0d", m, f), e_lr, 0);
        chk(rises == 2, $sformatf("R2 frame period %0d", p), rises, 2);
        chk(e_fa == 0, $sformatf("R4 fall enables mode=%0d fast=%0d", m, f), e_fa, 0);
        chk(falls0 == 64, $sformatf("R4 fall count per frame mode=%0d fast=%0d", m, f), falls0, 64);
        chk(e_ri == 0, $sformatf("R5 rise enables mode=%0d fast=%0d", m, f), e_ri, 0);
    endtask

    // Pins changed while running must not alter the captured ratio
    task automatic run_pin_change();
        int e_lr, e_fa, e_ri, falls0, rises;
        do_reset(2'b00, 1'b0);
        scan(256, 768, 37, e_lr, e_fa, e_ri, falls0, rises);
        chk(e_lr == 0, "R6 frame pattern kept after pin change", e_lr, 0);
        chk(e_fa == 0, "R6 fall enables kept after pin change", e_fa, 0);
        chk(e_ri == 0, "R6 rise enables kept after pin change", e_ri, 0);
        chk(drive == 1, "R6 drive kept after pin change", drive, 1);
        @(negedge mclk);
        mode = 2'b11;
        repeat (20) @(negedge mclk);
        chk(drive == 1, "R6 drive ignores late external code", drive, 1);
    endtask

    task automatic run_slave(input logic f);
        int busy;
        busy = 0;
        do_reset(2'b11, f);
        for (int k = 0; k < 600; k++) begin
            @(negedge mclk);
            if (lrck || sfall || srise) busy++;
        end
        chk(busy == 0, $sformatf("R8 external mode quiet fast=%0d", f), busy, 0);
        chk(drive == 0, "R1 drive low for code 11", drive, 0);
    endtask

    initial begin
        run_master(2'b00, 1'b0);
        run_master(2'b00, 1'b1);
        run_master(2'b01, 1'b0);
        run_master(2'b01, 1'b1);
        run_master(2'b10, 1'b0);
        run_master(2'b10, 1'b1);
        run_pin_change();
        run_slave(1'b0);
        run_slave(1'b1);
        run_master(2'b10, 1'b0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog R7 run did not finish actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule